// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block watches the stream of write cycles that a flash device receives and works out which command the host is entering. It recognises the two-cycle unlock prefix and then a program, an erase or an identification request. When a sequence is complete it fires a one-cycle start strobe toward an external embedded program or erase engine, and it drops its ready output until that engine reports completion. The engine is modelled only by a done input and an error input. The error input stands for the timeout flag of a real device.

Each write arrives already qualified, as one cycle of `wr_valid` with its address, data and sector index. The controller tells the read path what a read should return: array contents, status or identification data. While an erase is suspended, that answer depends on the sector index presented with the read. The controller accepts a reset command only at certain points. The reset command aborts a partly entered sequence and leaves identification mode or the error state. It has no effect while an engine is running.

Top module: `flash_cmd_seq`

## Requirements
- R1: After the synchronous reset input, `rd_mode` is 0 (array), `ready` is 1, and `erase_hold`, `prog_start` and `erase_start` are 0.
- R2: A program is entered as 0xAA at address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then the data byte at its target address. The cycle after the last write, `prog_start` is high for exactly one cycle and `pgm_addr`/`pgm_data` hold that address and data. From that cycle `ready` is 0 and `rd_mode` is 1 (status).
- R3: An erase is entered as the unlock pair, 0x80 at 0x555, the unlock pair again, and then either 0x10 at 0x555 or 0x30 at any address. The first gives `erase_all`=1. The second gives `erase_all`=0 with `erase_sector` equal to the `wr_sector` of that write. In both cases `erase_start` pulses one cycle and `ready` falls.
- R4: A wrong address or wrong data at any step of a sequence returns the controller to array mode. Later command cycles then start nothing.
- R5: 0xF0 at any address, written between the cycles of a program, erase or identification sequence, returns the controller to array mode.
- R6: While a program or erase is running, a 0xF0 write is ignored: `ready` stays 0 and `rd_mode` stays 1.
- R7: A done pulse during a running operation returns `rd_mode` to 0 and `ready` to 1 in the next cycle.
- R8: The unlock pair followed by 0x90 at 0x555 gives `rd_mode`=2 (identification). Only a 0xF0 write leaves it; other writes are ignored.
- R9: An error pulse during a running operation gives `rd_mode`=1 with `ready`=1. This holds through any write other than 0xF0, which returns to the previous read context.
- R10: 0xB0 at any address during an erase suspends it. `erase_hold` goes to 1 and `ready` to 1. A read whose `rd_sector` equals the erased sector gives `rd_mode` 1, and any other sector gives 0. After a chip erase, every sector gives 1.
- R11: While suspended, a program may be entered and may complete, and R10's read rule still holds afterwards. An erase setup (0x80) while suspended is rejected.
- R12: 0x30 while suspended and idle resumes the erase. `erase_hold` falls, `ready` falls, and `erase_start` does not pulse.
- R13: In the same cycle during a running operation, error takes precedence over done, and done takes precedence over a suspend write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One qualified write cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| wr_sector | input | SEC_W | Sector index of the write address |
| rd_sector | input | SEC_W | Sector index of the current read address |
| eng_done | input | 1 | Embedded engine finished |
| eng_error | input | 1 | Embedded engine timed out |
| rd_mode | output | 2 | 0 array, 1 status, 2 identification |
| ready | output | 1 | Low while an engine runs |
| prog_start | output | 1 | One-cycle program start strobe |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | 8 | Program data byte |
| erase_start | output | 1 | One-cycle erase start strobe |
| erase_all | output | 1 | Current erase covers the whole chip |
| erase_sector | output | SEC_W | Sector of the current sector erase |
| erase_hold | output | 1 | Erase is suspended |

## Verification
Completion of an erase and an incoming suspend write can land in the same cycle. The bench produces this by raising `eng_done` in the cycle that carries 0xB0 during a sector erase. The outcome is correct only if `erase_hold` stays 0, `ready` returns to 1 and reads give array data. A second collision raises done and error together during a program, and the expected outcome is that status is held until a 0xF0 write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int UNLK_AW = 11;
    localparam int DATA_W  = 8;

    localparam logic [UNLK_AW-1:0] ADDR_KEY1 = 11'h555;
    localparam logic [UNLK_AW-1:0] ADDR_KEY2 = 11'h2AA;

    localparam logic [DATA_W-1:0] CMD_RESET  = 8'hF0;
    localparam logic [DATA_W-1:0] CMD_KEY1   = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_KEY2   = 8'h55;
    localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_ESETUP = 8'h80;
    localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] CMD_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] CMD_SUSP   = 8'hB0;
    localparam logic [DATA_W-1:0] CMD_RESUME = 8'h30;
    localparam logic [DATA_W-1:0] CMD_IDENT  = 8'h90;

    typedef enum logic [3:0] {
        S_IDLE, S_U1, S_U2, S_PSETUP, S_ESETUP, S_EU1, S_EU2,
        S_IDENT, S_PBUSY, S_EBUSY, S_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2
    } rd_mode_t;

    typedef struct packed {
        logic              valid;
        logic              key1;
        logic              key2;
        logic              reset;
        logic              at_cmd;
        logic [DATA_W-1:0] code;
    } wr_class_t;

    function automatic logic is_running(input seq_state_t s);
        return (s == S_PBUSY) || (s == S_EBUSY);
    endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic               wr_valid,
    input  logic [UNLK_AW-1:0] cmd_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output wr_class_t          cls
);
    always_comb begin
        cls.valid  = wr_valid;
        cls.at_cmd = wr_valid && (cmd_addr == ADDR_KEY1);
        cls.key1   = cls.at_cmd && (wr_data == CMD_KEY1);
        cls.key2   = wr_valid && (cmd_addr == ADDR_KEY2) && (wr_data == CMD_KEY2);
        cls.reset  = wr_valid && (wr_data == CMD_RESET);
        cls.code   = wr_data;
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SEC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_class_t         cls,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEC_W-1:0]  wr_sector,
    input  logic              eng_done,
    input  logic              eng_error,
    output seq_state_t        state,
    output logic              suspended,
    output logic [SEC_W-1:0]  susp_sec,
    output logic              erase_all,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data
);
    seq_state_t nxt;
    logic       nsusp, go_prog, go_erase, go_all;

    always_comb begin
        nxt      = state;
        nsusp    = suspended;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        go_all   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cls.key1) nxt = S_U1;
                else if (cls.valid && suspended && cls.code == CMD_RESUME) begin
                    nxt   = S_EBUSY;
                    nsusp = 1'b0;
                end
            end
            S_U1:     if (cls.valid) nxt = cls.key2 ? S_U2 : S_IDLE;
            S_U2: begin
                if (cls.valid) begin
                    nxt = S_IDLE;
                    if (cls.at_cmd) begin
                        if (cls.code == CMD_PROG) nxt = S_PSETUP;
                        else if (cls.code == CMD_IDENT) nxt = S_IDENT;
                        else if (cls.code == CMD_ESETUP && !suspended) nxt = S_ESETUP;
                    end
                end
            end
            S_PSETUP: begin
                if (cls.reset) nxt = S_IDLE;
                else if (cls.valid) begin
                    nxt     = S_PBUSY;
                    go_prog = 1'b1;
                end
            end
            S_ESETUP: if (cls.valid) nxt = cls.key1 ? S_EU1 : S_IDLE;
            S_EU1:    if (cls.valid) nxt = cls.key2 ? S_EU2 : S_IDLE;
            S_EU2: begin
                if (cls.valid) begin
                    nxt = S_IDLE;
                    if (cls.at_cmd && cls.code == CMD_CHIP) begin
                        nxt      = S_EBUSY;
                        go_erase = 1'b1;
                        go_all   = 1'b1;
                    end else if (cls.code == CMD_SECT) begin
                        nxt      = S_EBUSY;
                        go_erase = 1'b1;
                    end
                end
            end
            S_IDENT, S_ERR: if (cls.reset) nxt = S_IDLE;
            S_PBUSY: begin
                if (eng_error) nxt = S_ERR;
                else if (eng_done) nxt = S_IDLE;
            end
            S_EBUSY: begin
                if (eng_error) nxt = S_ERR;
                else if (eng_done) nxt = S_IDLE;
                else if (cls.valid && cls.code == CMD_SUSP) begin
                    nxt   = S_IDLE;
                    nsusp = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            suspended   <= 1'b0;
            susp_sec    <= '0;
            erase_all   <= 1'b0;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            pgm_addr    <= '0;
            pgm_data    <= '0;
        end else begin
            state       <= nxt;
            suspended   <= nsusp;
            prog_start  <= go_prog;
            erase_start <= go_erase;
            if (go_prog) begin
                pgm_addr <= wr_addr;
                pgm_data <= cls.code;
            end
            if (go_erase) begin
                erase_all <= go_all;
                susp_sec  <= wr_sector;
            end
        end
    end

    p_prog_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);
    p_reset_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (is_running(state) && cls.reset && !eng_done && !eng_error) |=> (state == $past(state)));
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (is_running(state) && eng_done && !eng_error) |=> (state == S_IDLE));
    p_ident_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDENT && !cls.reset) |=> (state == S_IDENT));
    p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_ERR && !cls.reset) |=> (state == S_ERR));
    p_resume_r12: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && suspended && cls.valid && cls.code == CMD_RESUME)
        |=> (state == S_EBUSY && !suspended && !erase_start));
    p_error_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (is_running(state) && eng_error) |=> (state == S_ERR));
endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int SEC_W = 3
) (
    input  seq_state_t       state,
    input  logic             suspended,
    input  logic [SEC_W-1:0] susp_sec,
    input  logic             erase_all,
    input  logic [SEC_W-1:0] rd_sector,
    output rd_mode_t         mode,
    output logic             ready
);
    logic hit_susp;

    always_comb begin
        hit_susp = suspended && (erase_all || rd_sector == susp_sec);
        unique case (state)
            S_IDENT:               mode = RM_IDENT;
            S_PBUSY, S_EBUSY, S_ERR: mode = RM_STATUS;
            default:               mode = hit_susp ? RM_STATUS : RM_ARRAY;
        endcase
        ready = !is_running(state);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SEC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [SEC_W-1:0]  wr_sector,
    input  logic [SEC_W-1:0]  rd_sector,
    input  logic              eng_done,
    input  logic              eng_error,
    output logic [1:0]        rd_mode,
    output logic              ready,
    output logic              prog_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data,
    output logic              erase_start,
    output logic              erase_all,
    output logic [SEC_W-1:0]  erase_sector,
    output logic              erase_hold
);
    wr_class_t  cls;
    seq_state_t state;
    rd_mode_t   mode;

    flash_cmd_decode u_decode (
        .wr_valid (wr_valid),
        .cmd_addr (wr_addr[UNLK_AW-1:0]),
        .wr_data  (wr_data),
        .cls      (cls)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .wr_addr     (wr_addr),
        .wr_sector   (wr_sector),
        .eng_done    (eng_done),
        .eng_error   (eng_error),
        .state       (state),
        .suspended   (erase_hold),
        .susp_sec    (erase_sector),
        .erase_all   (erase_all),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .pgm_addr    (pgm_addr),
        .pgm_data    (pgm_data)
    );

    flash_cmd_rdmux #(.SEC_W(SEC_W)) u_rdmux (
        .state     (state),
        .suspended (erase_hold),
        .susp_sec  (erase_sector),
        .erase_all (erase_all),
        .rd_sector (rd_sector),
        .mode      (mode),
        .ready     (ready)
    );

    assign rd_mode = mode;

    p_busy_status_r6: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rd_mode == 2'd1));
    p_hold_ready_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_hold) |-> ready);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int ADDR_W = 18;
    localparam int SEC_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [SEC_W-1:0]  wr_sector = '0;
    logic [SEC_W-1:0]  rd_sector = '0;
    logic              eng_done = 1'b0;
    logic              eng_error = 1'b0;
    logic [1:0]        rd_mode;
    logic              ready, prog_start, erase_start, erase_all, erase_hold;
    logic [ADDR_W-1:0] pgm_addr;
    logic [7:0]        pgm_data;
    logic [SEC_W-1:0]  erase_sector;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_sector(wr_sector), .rd_sector(rd_sector),
        .eng_done(eng_done), .eng_error(eng_error), .rd_mode(rd_mode),
        .ready(ready), .prog_start(prog_start), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .erase_start(erase_start), .erase_all(erase_all),
        .erase_sector(erase_sector), .erase_hold(erase_hold)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_s(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input logic [SEC_W-1:0] s);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_sector = s;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_s(a, d, '0);
    endtask

    task automatic unlock();
        wr(18'h555, 8'hAA);
        wr(18'h2AA, 8'h55);
    endtask

    task automatic prog_seq(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(18'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_seq(input logic chip, input logic [SEC_W-1:0] s);
        unlock();
        wr(18'h555, 8'h80);
        unlock();
        if (chip) wr(18'h555, 8'h10);
        else wr_s(18'h100, 8'h30, s);
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); eng_error = 1'b1;
        @(negedge clk); eng_error = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rd_mode", rd_mode, 0);
        check("R1", "ready", ready, 1);
        check("R1", "erase_hold", erase_hold, 0);
        check("R1", "strobes", {prog_start, erase_start}, 0);
    endtask

    task automatic t_program();
        prog_seq(18'h1234, 8'h5A);
        check("R2", "prog_start", prog_start, 1);
        check("R2", "pgm_addr", pgm_addr, 18'h1234);
        check("R2", "pgm_data", pgm_data, 8'h5A);
        check("R2", "ready", ready, 0);
        check("R2", "rd_mode", rd_mode, 1);
        @(negedge clk);
        check("R2", "prog_start one cycle", prog_start, 0);
        wr(18'h3FF, 8'hF0);
        check("R6", "ready after reset cmd", ready, 0);
        check("R6", "rd_mode after reset cmd", rd_mode, 1);
        pulse_done();
        check("R7", "rd_mode after done", rd_mode, 0);
        check("R7", "ready after done", ready, 1);
    endtask

    task automatic t_mismatch();
        wr(18'h555, 8'hAA);
        wr(18'h2AB, 8'h55);
        check("R4", "rd_mode after bad addr", rd_mode, 0);
        wr(18'h555, 8'hA0);
        wr(18'h40, 8'h11);
        check("R4", "no program after bad addr", {prog_start, ready}, 2'b01);
        wr(18'h555, 8'hAA);
        wr(18'h2AA, 8'h56);
        wr(18'h555, 8'h90);
        check("R4", "no ident after bad data", rd_mode, 0);
    endtask

    task automatic t_reset_mid();
        unlock();
        wr(18'h3FF, 8'hF0);
        wr(18'h555, 8'hA0);
        wr(18'h40, 8'h22);
        check("R5", "reset aborts program", {prog_start, ready}, 2'b01);
        unlock();
        wr(18'h555, 8'hA0);
        wr(18'h077, 8'hF0);
        @(negedge clk);
        check("R5", "reset in program setup", {ready, rd_mode}, 3'b100);
        unlock();
        wr(18'h555, 8'h80);
        wr(18'h123, 8'hF0);
        unlock();
        wr(18'h555, 8'h10);
        check("R5", "reset aborts erase", {erase_start, ready}, 2'b01);
    endtask

    task automatic t_chip_erase();
        erase_seq(1'b1, '0);
        check("R3", "erase_start chip", erase_start, 1);
        check("R3", "erase_all", erase_all, 1);
        check("R3", "ready chip", ready, 0);
        pulse_done();
        check("R7", "ready after erase done", {ready, rd_mode}, 3'b100);
    endtask

    task automatic t_ident();
        unlock();
        wr(18'h555, 8'h90);
        check("R8", "ident mode", rd_mode, 2);
        wr(18'h555, 8'hAA);
        wr(18'h2AA, 8'h55);
        check("R8", "ident holds", rd_mode, 2);
        wr(18'h0, 8'hF0);
        check("R8", "ident exit", rd_mode, 0);
    endtask

    task automatic t_error();
        prog_seq(18'h20, 8'h33);
        pulse_err();
        check("R9", "error status", rd_mode, 1);
        check("R9", "error ready", ready, 1);
        wr(18'h555, 8'hA0);
        check("R9", "error holds", rd_mode, 1);
        wr(18'h9, 8'hF0);
        check("R9", "error cleared", rd_mode, 0);
    endtask

    task automatic t_suspend();
        erase_seq(1'b0, 3'd3);
        check("R3", "erase_start sector", erase_start, 1);
        check("R3", "erase sector kind", {erase_all, erase_sector}, 4'b0011);
        wr(18'h2, 8'hB0);
        check("R10", "hold", erase_hold, 1);
        check("R10", "ready suspended", ready, 1);
        rd_sector = 3'd3; #1;
        check("R10", "suspended sector status", rd_mode, 1);
        rd_sector = 3'd5; #1;
        check("R10", "other sector array", rd_mode, 0);
        prog_seq(18'h3000, 8'h7E);
        check("R11", "program in suspend", {prog_start, ready}, 2'b10);
        pulse_done();
        check("R11", "hold kept", {erase_hold, ready}, 2'b11);
        rd_sector = 3'd3; #1;
        check("R11", "status after program", rd_mode, 1);
        rd_sector = 3'd2; #1;
        check("R11", "array after program", rd_mode, 0);
        erase_seq(1'b1, '0);
        check("R11", "erase rejected in suspend", {erase_start, erase_hold, ready}, 3'b011);
        wr(18'h7, 8'h30);
        check("R12", "resume", {erase_hold, ready, erase_start}, 3'b000);
        pulse_done();
        check("R12", "erase completes", ready, 1);
    endtask

    task automatic t_chip_suspend();
        erase_seq(1'b1, '0);
        wr(18'h0, 8'hB0);
        rd_sector = 3'd0; #1;
        check("R10", "chip suspend sector 0", rd_mode, 1);
        rd_sector = 3'd7; #1;
        check("R10", "chip suspend sector 7", rd_mode, 1);
        wr(18'h0, 8'h30);
        pulse_done();
        check("R10", "chip erase finished", {erase_hold, ready, rd_mode}, 4'b0100);
    endtask

    task automatic t_coincide();
        erase_seq(1'b0, 3'd1);
        rd_sector = 3'd1;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 18'h0; wr_data = 8'hB0; eng_done = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; eng_done = 1'b0;
        check("R13", "done beats suspend", {erase_hold, ready, rd_mode}, 4'b0100);
        prog_seq(18'h50, 8'h01);
        @(negedge clk);
        eng_done = 1'b1; eng_error = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_error = 1'b0;
        check("R13", "error beats done", rd_mode, 1);
        wr(18'h0, 8'hF0);
        check("R13", "cleared after collision", rd_mode, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_program();
        t_mismatch();
        t_reset_mid();
        t_chip_erase();
        t_ident();
        t_error();
        t_suspend();
        t_chip_suspend();
        t_coincide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule